// File: doc/BRIEF.md
# Selectable-Pin Port Interrupt Generator

This block turns a pool of general-purpose input pins into eight independent interrupt factors. Each factor owns a 2-bit source field that picks one of its four candidate pins, a sense bit that makes either the high/rising or the low/falling side of that pin active, and a trigger-kind bit that chooses between firing on a transition and firing while the active level is held. A detected condition sets that factor's pending bit. The pending bits, masked by a per-factor enable, are ORed into a single request line.

Software configures and services the block through a small register bus. Pending bits are cleared by writing ones. The candidate pins are asynchronous to the block clock, so they pass through a two-flop synchronizer before any detection. A configuration write never produces a false transition event, even when it changes which pin a factor watches or which sense it treats as active.

Top module: `pin_irq_gen`

## Requirements
- R1: After reset every register reads 0, `irq_flags` is 0 and `irq_req` is low.
- R2: Factor f watches `cand_pins[4*f + s]`, where s is its 2-bit source field. Factors 0..3 keep their fields in the register at address 0 and factors 4..7 in the register at address 1. Factor f's field sits at bits [2*(f%4)+1 : 2*(f%4)]. The other three candidates of a factor have no effect on it.
- R3: Bit f of the register at address 2 is factor f's sense. 0 makes high/rising active and 1 makes low/falling active.
- R4: When bit f of the register at address 3 is 0 (level kind), flag f is set on each cycle in which the synchronized pin is at its active level. A clear that arrives while the level holds gives a 0 for one cycle, and the flag is set again on the following cycle.
- R5: When bit f of the register at address 3 is 1 (transition kind), flag f is set when the synchronized, sense-adjusted pin goes from inactive to active. The flag becomes visible after the third rising clock edge that follows the pin change.
- R6: Writing the register at address 4 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. Flags never drop without such a write. A transition event in the same cycle as the clear wins over the clear.
- R7: A write to any of addresses 0..3 never by itself causes a transition event, even when the newly selected source or sense is active.
- R8: `irq_req` is high exactly when some bit of `irq_flags` ANDed with the enable register at address 5 is 1.
- R9: Addresses 0, 1, 2, 3 and 5 read back the last value written to them, and address 4 reads the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cand_pins | input | 32 | Candidate pins, four per factor |
| irq_flags | output | 8 | Pending flag per factor |
| irq_req | output | 1 | Combined, enabled interrupt request |

## Verification
Several invariants are checked on every cycle. Flags never fall without a clear write. A clear with no coincident transition event always removes its bits. Level and transition hits always show up as flags in the next cycle. The cycle after a configuration write never carries a transition event. Source mapping, sense inversion, the three-edge synchronizer latency, re-arming in level mode and enable masking depend on pin stimulus and register contents. Directed scenarios show these, along with a randomized run of pins and writes compared each cycle against a bench model.

// File: rtl/pirq_pkg.sv
`timescale 1ns/1ps
package pirq_pkg;
  localparam int NUM_FACT  = 8;
  localparam int NUM_CAND  = 4;
  localparam int SEL_W     = $clog2(NUM_CAND);
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int PIN_W     = NUM_FACT * NUM_CAND;
  localparam int SELV_W    = NUM_FACT * SEL_W;

  typedef enum logic [ADDR_W-1:0] {
    RA_SRC_LO = 3'd0,
    RA_SRC_HI = 3'd1,
    RA_SENSE  = 3'd2,
    RA_KIND   = 3'd3,
    RA_FLAGS  = 3'd4,
    RA_ENABLE = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/pirq_rst_sync.sv
`timescale 1ns/1ps
module pirq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;
  logic [1:0] stg_n;

  always_comb stg_n = {stg_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= stg_n;
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/pirq_sync.sv
`timescale 1ns/1ps
module pirq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;
  logic [W-1:0] s1_n, s2_n;

  always_comb begin
    s1_n = d;
    s2_n = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_n;
      s2_q <= s2_n;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/pirq_detect.sv
`timescale 1ns/1ps
module pirq_detect #(
  parameter int NF = 8,
  parameter int NC = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NF*NC-1:0]          pins_s,
  input  logic [NF*$clog2(NC)-1:0]  sel_all,
  input  logic [NF-1:0]             sense,
  input  logic [NF-1:0]             kind_edge,
  input  logic                      cfg_wr,
  output logic [NF-1:0]             adj,
  output logic [NF-1:0]             edge_hit,
  output logic [NF-1:0]             lvl_hit
);
  localparam int SW = $clog2(NC);

  logic [NF-1:0] prev_q, prev_n;
  logic          mask_q, mask_n;

  for (genvar f = 0; f < NF; f++) begin : g_fact
    logic [NC-1:0] cand;
    logic [SW-1:0] pick;
    assign cand        = pins_s[f*NC +: NC];
    assign pick        = sel_all[f*SW +: SW];
    assign adj[f]      = cand[pick] ^ sense[f];
    assign edge_hit[f] = kind_edge[f] & adj[f] & ~prev_q[f] & ~mask_q;
    assign lvl_hit[f]  = ~kind_edge[f] & adj[f];
  end

  always_comb begin
    prev_n = adj;
    mask_n = cfg_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      mask_q <= 1'b0;
    end else begin
      prev_q <= prev_n;
      mask_q <= mask_n;
    end
  end
endmodule

// File: rtl/pirq_regs.sv
`timescale 1ns/1ps
module pirq_regs
  import pirq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_FACT-1:0] edge_hit,
  input  logic [NUM_FACT-1:0] lvl_hit,
  output logic [SELV_W-1:0]   sel_all,
  output logic [NUM_FACT-1:0] sense,
  output logic [NUM_FACT-1:0] kind_edge,
  output logic [NUM_FACT-1:0] enable,
  output logic [NUM_FACT-1:0] flags,
  output logic                cfg_wr
);
  logic [DATA_W-1:0]   src_lo_q, src_hi_q, sense_q, kind_q, en_q;
  logic [DATA_W-1:0]   src_lo_n, src_hi_n, sense_n, kind_n, en_n;
  logic [NUM_FACT-1:0] flag_q, flag_n, clr_v;
  logic                wr_lo, wr_hi, wr_sense, wr_kind, wr_flag, wr_en;

  always_comb begin
    wr_lo    = bus_we && (bus_addr == RA_SRC_LO);
    wr_hi    = bus_we && (bus_addr == RA_SRC_HI);
    wr_sense = bus_we && (bus_addr == RA_SENSE);
    wr_kind  = bus_we && (bus_addr == RA_KIND);
    wr_flag  = bus_we && (bus_addr == RA_FLAGS);
    wr_en    = bus_we && (bus_addr == RA_ENABLE);
    cfg_wr   = wr_lo | wr_hi | wr_sense | wr_kind;
    clr_v    = wr_flag ? bus_wdata : '0;
  end

  always_comb begin
    src_lo_n = wr_lo    ? bus_wdata : src_lo_q;
    src_hi_n = wr_hi    ? bus_wdata : src_hi_q;
    sense_n  = wr_sense ? bus_wdata : sense_q;
    kind_n   = wr_kind  ? bus_wdata : kind_q;
    en_n     = wr_en    ? bus_wdata : en_q;
    // a transition event beats a clear; a held level yields for one cycle
    flag_n   = (flag_q & ~clr_v) | edge_hit | (lvl_hit & ~clr_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_lo_q <= '0;
      src_hi_q <= '0;
      sense_q  <= '0;
      kind_q   <= '0;
      en_q     <= '0;
      flag_q   <= '0;
    end else begin
      src_lo_q <= src_lo_n;
      src_hi_q <= src_hi_n;
      sense_q  <= sense_n;
      kind_q   <= kind_n;
      en_q     <= en_n;
      flag_q   <= flag_n;
    end
  end

  always_comb begin
    case (bus_addr)
      RA_SRC_LO: bus_rdata = src_lo_q;
      RA_SRC_HI: bus_rdata = src_hi_q;
      RA_SENSE:  bus_rdata = sense_q;
      RA_KIND:   bus_rdata = kind_q;
      RA_FLAGS:  bus_rdata = flag_q;
      RA_ENABLE: bus_rdata = en_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign sel_all   = {src_hi_q, src_lo_q};
  assign sense     = sense_q;
  assign kind_edge = kind_q;
  assign enable    = en_q;
  assign flags     = flag_q;

  // R6: a flag only falls after a clear write to its bit
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(flag_q) & ~flag_q) & ~$past(clr_v)) == '0));

  // R6: a clear with no coincident transition event removes the bit
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & $past(clr_v & ~edge_hit)) == '0));

  // R4: a level hit not being cleared always shows as a flag
  assert_level_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flag_q & $past(lvl_hit & ~clr_v)) == '0));

  // R5: a transition hit always shows as a flag
  assert_edge_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flag_q & $past(edge_hit)) == '0));
endmodule

// File: rtl/pin_irq_gen.sv
`timescale 1ns/1ps
module pin_irq_gen
  import pirq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [PIN_W-1:0]    cand_pins,
  output logic [NUM_FACT-1:0] irq_flags,
  output logic                irq_req
);
  logic                rst_sync_n;
  logic [PIN_W-1:0]    pins_s;
  logic [SELV_W-1:0]   sel_all;
  logic [NUM_FACT-1:0] sense, kind_edge, enable, flags;
  logic [NUM_FACT-1:0] adj, edge_hit, lvl_hit;
  logic                cfg_wr;

  pirq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pirq_sync #(.W(PIN_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (cand_pins),
    .q     (pins_s)
  );

  pirq_detect #(.NF(NUM_FACT), .NC(NUM_CAND)) u_det (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pins_s    (pins_s),
    .sel_all   (sel_all),
    .sense     (sense),
    .kind_edge (kind_edge),
    .cfg_wr    (cfg_wr),
    .adj       (adj),
    .edge_hit  (edge_hit),
    .lvl_hit   (lvl_hit)
  );

  pirq_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .edge_hit  (edge_hit),
    .lvl_hit   (lvl_hit),
    .sel_all   (sel_all),
    .sense     (sense),
    .kind_edge (kind_edge),
    .enable    (enable),
    .flags     (flags),
    .cfg_wr    (cfg_wr)
  );

  assign irq_flags = flags;
  assign irq_req   = |(flags & enable);

  // R7: the cycle after a configuration write carries no transition event
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(cfg_wr) |-> (edge_hit == '0));

  // R8: request falls only when the enabled flags were cleared or masked
  assert_req_source_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(irq_req) |-> ($past(bus_we) && (($past(bus_addr) == RA_FLAGS) || ($past(bus_addr) == RA_ENABLE))));
endmodule

// File: tb/tb_pin_irq_gen.sv
`timescale 1ns/1ps
module tb_pin_irq_gen;
  localparam int PER = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] cand_pins = '0;
  logic [7:0]  irq_flags;
  logic        irq_req;

  int n_chk = 0;
  int n_bad = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  pin_irq_gen dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cand_pins(cand_pins),
    .irq_flags(irq_flags), .irq_req(irq_req)
  );

  always #(PER/2) clk = ~clk;

  // reference state built from the requirements
  logic [7:0]  m_lo = '0, m_hi = '0, m_sense = '0, m_kind = '0, m_en = '0, m_flags = '0, m_prev = '0;
  logic [31:0] m_s1 = '0, m_s2 = '0;
  logic        m_mask = 1'b0;

  function automatic logic [7:0] exp_adj(logic [31:0] p, logic [7:0] lo, logic [7:0] hi, logic [7:0] sn);
    logic [7:0] r;
    for (int f = 0; f < 8; f++) begin
      int s;
      s = (f < 4) ? int'(lo[2*f +: 2]) : int'(hi[2*(f-4) +: 2]);
      r[f] = p[4*f + s] ^ sn[f];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (model_on) begin
      logic [7:0] a, he, hl, clr;
      a   = exp_adj(m_s2, m_lo, m_hi, m_sense);
      he  = m_kind & a & ~m_prev & {8{~m_mask}};
      hl  = ~m_kind & a;
      clr = (bus_we && bus_addr == 3'd4) ? bus_wdata : 8'h00;
      m_flags = (m_flags & ~clr) | he | (hl & ~clr);
      m_prev  = a;
      m_mask  = bus_we && (bus_addr <= 3'd3);
      m_s2 = m_s1;
      m_s1 = cand_pins;
      if (bus_we) begin
        case (bus_addr)
          3'd0: m_lo = bus_wdata;
          3'd1: m_hi = bus_wdata;
          3'd2: m_sense = bus_wdata;
          3'd3: m_kind = bus_wdata;
          3'd5: m_en = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      chk("R4 R5 R6 flags vs model", {24'd0, irq_flags}, {24'd0, m_flags});
      chk("R8 request vs model", {31'd0, irq_req}, {31'd0, |(m_flags & m_en)});
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(tag, {24'd0, bus_rdata}, {24'd0, exp});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(PER * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7431));
    idle(3);
    rst_n = 1'b1;
    idle(4);
    model_on = 1'b1;

    // R1 reset state
    chk("R1 flags", {24'd0, irq_flags}, 32'd0);
    chk("R1 req", {31'd0, irq_req}, 32'd0);
    for (int a = 0; a < 6; a++) rd_chk("R1 register", 3'(a), 8'h00);

    // R9 readback
    wr(3'd0, 8'hE4); wr(3'd1, 8'h1B); wr(3'd2, 8'h5A); wr(3'd3, 8'hC3); wr(3'd5, 8'h3C);
    rd_chk("R9 src lo", 3'd0, 8'hE4);
    rd_chk("R9 src hi", 3'd1, 8'h1B);
    rd_chk("R9 sense", 3'd2, 8'h5A);
    rd_chk("R9 kind", 3'd3, 8'hC3);
    rd_chk("R9 enable", 3'd5, 8'h3C);
    rd_chk("R9 flags", 3'd4, m_flags);

    // factor 5 on candidate 2 (pin 22), rising transition
    wr(3'd2, 8'h00); wr(3'd3, 8'hFF); wr(3'd5, 8'hFF);
    wr(3'd0, 8'h00); wr(3'd1, 8'h08); wr(3'd4, 8'hFF);
    idle(4);
    chk("R5 quiet", {24'd0, irq_flags}, 32'd0);

    // R2 other candidate of factor 5 is ignored
    cand_pins[21] = 1'b1;
    idle(5);
    chk("R2 unselected pin", {24'd0, irq_flags}, 32'd0);

    // R5 latency: visible after third rising edge
    @(negedge clk); cand_pins[22] = 1'b1;
    idle(2);
    chk("R5 before third edge", {24'd0, irq_flags}, 32'd0);
    idle(1);
    chk("R5 after third edge R2", {24'd0, irq_flags}, 32'h20);
    chk("R8 req on", {31'd0, irq_req}, 32'd1);

    // R8 masking
    wr(3'd5, 8'hDF);
    chk("R8 masked", {31'd0, irq_req}, 32'd0);
    wr(3'd5, 8'hFF);
    chk("R8 unmasked", {31'd0, irq_req}, 32'd1);

    // R6 clear semantics
    wr(3'd4, 8'hDF);
    chk("R6 zero bits keep", {24'd0, irq_flags}, 32'h20);
    wr(3'd4, 8'h20);
    chk("R6 cleared", {24'd0, irq_flags}, 32'd0);
    idle(3);
    chk("R6 held pin no refire", {24'd0, irq_flags}, 32'd0);

    // R7 source change to an active pin
    cand_pins[22] = 1'b0; cand_pins[20] = 1'b1;
    idle(4);
    wr(3'd4, 8'hFF);
    wr(3'd1, 8'h00);
    idle(4);
    chk("R7 source switch", {24'd0, irq_flags}, 32'd0);
    // R7 sense change making the pin active
    cand_pins[20] = 1'b0;
    idle(4);
    wr(3'd2, 8'h20);
    idle(4);
    chk("R7 sense switch", {24'd0, irq_flags}, 32'd0);

    // R3 low/falling sense
    @(negedge clk); cand_pins[20] = 1'b1;
    idle(4);
    chk("R3 rising ignored", {24'd0, irq_flags}, 32'd0);
    @(negedge clk); cand_pins[20] = 1'b0;
    idle(3);
    chk("R3 falling fires", {24'd0, irq_flags}, 32'h20);
    wr(3'd4, 8'hFF);

    // R4 level kind, clear while active re-arms next cycle
    wr(3'd3, 8'hDF);
    idle(2);
    chk("R4 level set", {24'd0, irq_flags}, 32'h20);
    wr(3'd4, 8'h20);
    chk("R4 cleared cycle", {24'd0, irq_flags}, 32'd0);
    idle(1);
    chk("R4 set again", {24'd0, irq_flags}, 32'h20);
    cand_pins[20] = 1'b1;
    wr(3'd3, 8'hFF);
    idle(3);
    wr(3'd4, 8'hFF);

    // randomized phase against the model
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      cand_pins = cand_pins ^ ($urandom() & $urandom() & $urandom());
      if (($urandom() & 32'hF) == 0) begin
        bus_addr  = 3'($urandom() % 6);
        bus_wdata = 8'($urandom());
        bus_we    = 1'b1;
      end else begin
        bus_we = 1'b0;
      end
    end
    @(negedge clk); bus_we = 1'b0;
    for (int a = 0; a < 6; a++) begin
      logic [7:0] e;
      case (a)
        0: e = m_lo; 1: e = m_hi; 2: e = m_sense;
        3: e = m_kind; 4: e = m_flags; default: e = m_en;
      endcase
      rd_chk("R9 random readback", 3'(a), e);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule